// File: doc/BRIEF.md
# NAND Program, Erase and Read Sequencer

This block sits on the host side of an 8-bit multiplexed NAND-style bus. It takes one request at a time and turns it into the cycles the device expects. A request is a page program, a block erase or a page read, and it carries a start column, a 16-bit row (page) address and a byte count. Commands, addresses and data all travel over one byte-wide bus. A command-latch strobe and an address-latch strobe tell the device which kind of byte a write-enable pulse carries. Read data comes back on read-enable strobes.

For a program or erase, the sequencer sends the confirm command and then waits out the write-to-busy window. It then finds completion by sending the status command and reading the status byte again and again until the ready bit (bit 6) is set. It reports pass or fail from status bit 0. If the `POLL` parameter is 0, it waits on the ready/busy line instead and reads status once. A page read always waits on the ready/busy line and then strobes out the requested bytes.

Every setup, pulse, hold and turnaround time is a parameter counted in clock cycles. A timeout counter ends an operation with an error if the device stays busy too long.

Top module: `nand_seq`

## Requirements
- R1: After reset the bus is idle: write-enable and read-enable are high, both latch strobes are low, the data driver is off, `req_ready` is 1 and `done` is 0.
- R2: A program (`req_op`=0) sends the pointer command, then 80h, then the column byte, then the row low byte, then the row high byte. It then sends `req_len` data bytes with both strobes low, and then 10h.
- R3: The pointer command comes from `req_area`: 0 selects 00h (first half), 1 selects 01h (second half), 2 or 3 selects 50h (spare). For a program it always stands directly before 80h, with no cycle between them.
- R4: An erase (`req_op`=1) sends 60h, then two row bytes, then D0h. It sends no pointer command and no column byte, and the row's lowest `PG_BITS` bits are sent as 0.
- R5: After 10h or D0h, the sequencer waits `T_WB` cycles and sends 70h. It then reads the status byte until bit 6 is 1, and pulses `done` with `fail` equal to status bit 0.
- R6: A read (`req_op`=2) sends the pointer command, the column byte and the two row bytes. It waits `T_WB` cycles, then waits for `nand_rb` to be high, then waits `T_WHR` cycles. It then makes `req_len` read-enable strobes, and each sampled byte appears on `rd_data` with a one-cycle `rd_valid`.
- R7: If the device is still busy after `TIMEOUT` cycles of waiting, `done` pulses with both `fail` and `timeout` set to 1.
- R8: Write-enable stays low for exactly `T_WP` cycles. The latch strobes and the data byte do not change while it is low or on the cycle it rises. Read-enable falls no earlier than `T_WHR` cycles after the last write-enable pulse, and never while the bus driver is on.
- R9: `done` is a one-cycle pulse. A `req_valid` raised while an operation is running has no effect: no bus cycle comes from it.
- R10: During a program, `wr_take` pulses once per data byte, for `req_len` pulses in total. The next byte must be on `wr_data` after each pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Start a request (taken when `req_ready`) |
| req_op | input | 2 | 0 program, 1 erase, 2 read |
| req_area | input | 2 | Pointer area: 0 first half, 1 second half, 2/3 spare |
| req_col | input | 8 | Start column within the area |
| req_row | input | 16 | Page (row) address |
| req_len | input | LEN_W | Bytes to load or read |
| req_ready | output | 1 | Idle and able to take a request |
| wr_data | input | 8 | Current program data byte |
| wr_take | output | 1 | Current program byte has been sent |
| rd_data | output | 8 | Byte read from the device |
| rd_valid | output | 1 | `rd_data` holds a new byte |
| done | output | 1 | Operation finished (one cycle) |
| fail | output | 1 | Device reported failure or timeout, valid with `done` |
| timeout | output | 1 | Busy wait exceeded the limit, valid with `done` |
| nand_cle | output | 1 | Command latch strobe |
| nand_ale | output | 1 | Address latch strobe |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_dq_oe | output | 1 | Drive enable for `nand_dq_out` |
| nand_dq_out | output | 8 | Byte driven to the device |
| nand_dq_in | input | 8 | Byte returned by the device |
| nand_rb | input | 1 | Ready (1) or busy (0) |

## Verification
The in-line properties check the bus timing on every cycle: the write-enable pulse width, that strobes and data stay stable through each write pulse, the gap from write-enable to read-enable, and that read-enable is never low while the bus is driven. They also check that `done` is a single-cycle pulse, that a timeout always comes with a failure, and that a taken request closes `req_ready`. The order and content of the command, address and data bytes can only be shown by the bench scenarios, because they depend on the request. The same is true of the pointer code per area, the masked erase row, the pass/fail taken from the polled status, the timeout path, the read-data stream and the ignored mid-operation request. The bench checks these against a bus-level device model.

// File: rtl/nand_seq.sv
module nand_seq #(
  parameter int T_SU    = 4,
  parameter int T_WP    = 5,
  parameter int T_HD    = 2,
  parameter int T_WB    = 20,
  parameter int T_WHR   = 12,
  parameter int T_RP    = 6,
  parameter int T_REH   = 4,
  parameter int TIMEOUT = 4096,
  parameter int LEN_W   = 10,
  parameter int PG_BITS = 4,
  parameter int POLL    = 1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [1:0]       req_area,
  input  logic [7:0]       req_col,
  input  logic [15:0]      req_row,
  input  logic [LEN_W-1:0] req_len,
  output logic             req_ready,
  input  logic [7:0]       wr_data,
  output logic             wr_take,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             done,
  output logic             fail,
  output logic             timeout,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic             nand_dq_oe,
  output logic [7:0]       nand_dq_out,
  input  logic [7:0]       nand_dq_in,
  input  logic             nand_rb
);
  localparam int CW = 8;
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [15:0] PG_MASK = 16'((1 << PG_BITS) - 1);
  localparam logic [1:0] OP_PROG = 2'd0, OP_ERASE = 2'd1;

  typedef enum logic [3:0] {
    S_IDLE, S_PTR, S_CMD1, S_A0, S_A1, S_A2, S_DATA, S_CMD2,
    S_WB, S_BUSY, S_STCMD, S_WHR, S_STRD, S_RDATA, S_DONE
  } step_t;

  step_t            step, nxt_wr;
  logic [1:0]       ph, op, area;
  logic [CW-1:0]    cnt, ph_len;
  logic [LEN_W-1:0] bcnt, len;
  logic [TW-1:0]    tmo;
  logic [7:0]       col;
  logic [15:0]      row, row_o;
  logic             st_rdy, st_err, is_wr, is_rd, last_ph, item_end, rd_op, tmo_hit;

  assign is_wr = step inside {S_PTR, S_CMD1, S_A0, S_A1, S_A2, S_DATA, S_CMD2, S_STCMD};
  assign is_rd = step inside {S_STRD, S_RDATA};
  assign rd_op = !(op inside {OP_PROG, OP_ERASE});
  assign ph_len = is_rd ? (ph == 2'd0 ? CW'(T_RP) : CW'(T_REH))
                        : (ph == 2'd0 ? CW'(T_SU) : ph == 2'd1 ? CW'(T_WP) : CW'(T_HD));
  assign last_ph  = is_rd ? (ph == 2'd1) : (ph == 2'd2);
  assign item_end = (is_wr || is_rd) && last_ph && (cnt == ph_len - 1'b1);
  assign tmo_hit  = (tmo >= TW'(TIMEOUT));
  assign row_o    = (op == OP_ERASE) ? (row & ~PG_MASK) : row;

  assign req_ready  = (step == S_IDLE);
  assign done       = (step == S_DONE);
  assign wr_take    = (step == S_DATA) && item_end;
  assign nand_cle   = step inside {S_PTR, S_CMD1, S_CMD2, S_STCMD};
  assign nand_ale   = step inside {S_A0, S_A1, S_A2};
  assign nand_dq_oe = is_wr;
  assign nand_we_n  = !(is_wr && ph == 2'd1);
  assign nand_re_n  = !(is_rd && ph == 2'd0);

  always_comb begin
    case (step)
      S_PTR:   nand_dq_out = (area == 2'd0) ? 8'h00 : (area == 2'd1) ? 8'h01 : 8'h50;
      S_CMD1:  nand_dq_out = (op == OP_ERASE) ? 8'h60 : 8'h80;
      S_A0:    nand_dq_out = col;
      S_A1:    nand_dq_out = row_o[7:0];
      S_A2:    nand_dq_out = row_o[15:8];
      S_DATA:  nand_dq_out = wr_data;
      S_CMD2:  nand_dq_out = (op == OP_ERASE) ? 8'hD0 : 8'h10;
      S_STCMD: nand_dq_out = 8'h70;
      default: nand_dq_out = 8'h00;
    endcase
  end

  always_comb begin
    case (step)
      S_PTR:   nxt_wr = rd_op ? S_A0 : S_CMD1;
      S_CMD1:  nxt_wr = (op == OP_ERASE) ? S_A1 : S_A0;
      S_A0:    nxt_wr = S_A1;
      S_A1:    nxt_wr = S_A2;
      S_A2:    nxt_wr = rd_op ? S_WB : (op == OP_PROG && len != '0) ? S_DATA : S_CMD2;
      S_DATA:  nxt_wr = (bcnt == len - 1'b1) ? S_CMD2 : S_DATA;
      S_CMD2:  nxt_wr = S_WB;
      default: nxt_wr = S_WHR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= S_IDLE; ph <= '0; cnt <= '0; bcnt <= '0; tmo <= '0;
      op <= '0; area <= '0; col <= '0; row <= '0; len <= '0;
      st_rdy <= 1'b0; st_err <= 1'b0; rd_data <= '0; rd_valid <= 1'b0;
      fail <= 1'b0; timeout <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (step)
        S_IDLE: if (req_valid) begin
          op <= req_op; area <= req_area; col <= req_col; row <= req_row; len <= req_len;
          bcnt <= '0; tmo <= '0; fail <= 1'b0; timeout <= 1'b0; ph <= '0; cnt <= '0;
          step <= (req_op == OP_ERASE) ? S_CMD1 : S_PTR;
        end
        S_WB: if (cnt == CW'(T_WB - 1)) begin
          cnt  <= '0;
          step <= (rd_op || POLL == 0) ? S_BUSY : S_STCMD;
        end else cnt <= cnt + 1'b1;
        S_WHR: if (cnt == CW'(T_WHR - 1)) begin
          cnt  <= '0;
          step <= !rd_op ? S_STRD : (len == '0) ? S_DONE : S_RDATA;
        end else cnt <= cnt + 1'b1;
        S_BUSY: if (nand_rb) begin
          cnt  <= '0;
          step <= rd_op ? S_WHR : S_STCMD;
        end else if (tmo_hit) begin
          fail <= 1'b1; timeout <= 1'b1; step <= S_DONE;
        end else tmo <= tmo + 1'b1;
        S_DONE: step <= S_IDLE;
        default: begin
          if (step == S_STRD && !tmo_hit) tmo <= tmo + 1'b1;
          if (is_rd && ph == 2'd0 && cnt == CW'(T_RP - 1)) begin
            if (step == S_STRD) begin
              st_rdy <= nand_dq_in[6]; st_err <= nand_dq_in[0];
            end else begin
              rd_data <= nand_dq_in; rd_valid <= 1'b1;
            end
          end
          if (cnt == ph_len - 1'b1) begin
            cnt <= '0;
            ph  <= last_ph ? 2'd0 : ph + 1'b1;
          end else cnt <= cnt + 1'b1;
          if (item_end) begin
            if (step == S_DATA || step == S_RDATA) bcnt <= bcnt + 1'b1;
            if (step == S_STRD) begin
              if (st_rdy || POLL == 0) begin
                fail <= st_err; step <= S_DONE;
              end else if (tmo_hit) begin
                fail <= 1'b1; timeout <= 1'b1; step <= S_DONE;
              end
            end else if (step == S_RDATA) begin
              if (bcnt == len - 1'b1) step <= S_DONE;
            end else step <= nxt_wr;
          end
        end
      endcase
    end
  end

  logic [7:0] we_lo_run, since_we;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_lo_run <= '0; since_we <= 8'hFF;
    end else begin
      we_lo_run <= nand_we_n ? 8'd0 : we_lo_run + 1'b1;
      since_we  <= !nand_we_n ? 8'd0 : (since_we == 8'hFF ? since_we : since_we + 1'b1);
    end
  end

  p_we_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_we_n) |-> we_lo_run == 8'(T_WP));
  p_bus_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!nand_we_n) |-> ($stable(nand_dq_out) && $stable(nand_cle) && $stable(nand_ale)));
  p_whr_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nand_re_n) |-> since_we >= 8'(T_WHR));
  p_no_contention_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> (!nand_dq_oe && nand_we_n));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_take_closes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  p_timeout_fails_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && timeout) |-> fail);
endmodule

// File: tb/nand_seq_bench.sv
module nand_seq_bench;
  localparam int T_WP = 5;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       req_valid = 1'b0;
  logic [1:0] req_op = '0, req_area = '0;
  logic [7:0] req_col = '0;
  logic [15:0] req_row = '0;
  logic [9:0] req_len = '0;
  logic req_ready, wr_take, rd_valid, done, fail, timeout;
  logic [7:0] wr_data, rd_data, dq_out, dq_in;
  logic cle, ale, we_n, re_n, dq_oe, rb;

  nand_seq #(.TIMEOUT(500)) u_nand_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_area(req_area),
    .req_col(req_col), .req_row(req_row), .req_len(req_len), .req_ready(req_ready),
    .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
    .done(done), .fail(fail), .timeout(timeout), .nand_cle(cle), .nand_ale(ale),
    .nand_we_n(we_n), .nand_re_n(re_n), .nand_dq_oe(dq_oe), .nand_dq_out(dq_out),
    .nand_dq_in(dq_in), .nand_rb(rb));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // device model
  logic [15:0] bsy = '0, busy_len = 16'd50;
  logic st_mode = 1'b0, sts_fail = 1'b0, weq = 1'b1, req_q = 1'b1;
  logic [7:0] cmd = '0, cbase = '0, ri = '0;
  logic [1:0] acnt = '0;
  assign rb = (bsy == 16'd0);
  assign dq_in = st_mode ? {1'b1, rb, 5'b0, sts_fail} : cbase + ri;
  always @(posedge clk) begin
    weq <= we_n; req_q <= re_n;
    if (bsy != 16'd0) bsy <= bsy - 1'b1;
    if (we_n && !weq) begin
      if (cle) begin
        cmd <= dq_out; st_mode <= (dq_out == 8'h70); acnt <= '0;
        if (dq_out == 8'h10 || dq_out == 8'hD0) bsy <= busy_len;
      end else if (ale) begin
        acnt <= acnt + 1'b1;
        if (acnt == 2'd0) cbase <= dq_out;
        if (acnt == 2'd2 && (cmd == 8'h00 || cmd == 8'h01 || cmd == 8'h50)) begin
          bsy <= busy_len; ri <= '0;
        end
      end
    end
    if (re_n && !req_q && !st_mode) ri <= ri + 1'b1;
  end

  // program data source
  int widx = 0, wstart = 0;
  logic [7:0] pbase = '0;
  assign wr_data = pbase + 8'(widx - wstart);
  always @(posedge clk) if (wr_take) widx <= widx + 1;

  // scoreboard
  logic [9:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] exp_rd[$];
  logic [1:0] exp_res[$];
  string      res_tag[$];

  task automatic push(input logic [7:0] b, input logic c, input logic a, input string t);
    exp_q.push_back({c, a, b});
    tag_q.push_back(t);
  endtask

  logic we_prev = 1'b1;
  int lo_cnt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!we_n) lo_cnt++;
      else if (!we_prev) begin
        check(lo_cnt == T_WP, "R8 we low width", lo_cnt, T_WP);
        lo_cnt = 0;
        if (exp_q.size() == 0) check(0, "R9 unexpected bus cycle", {cle, ale, dq_out}, 0);
        else begin
          logic [9:0] e; string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          check({cle, ale, dq_out} == e, t, {cle, ale, dq_out}, e);
        end
      end
      if (rd_valid) begin
        if (exp_rd.size() == 0) check(0, "R6 unexpected read byte", rd_data, 0);
        else begin
          logic [7:0] e;
          e = exp_rd.pop_front();
          check(rd_data == e, "R6 read byte", rd_data, e);
        end
      end
      if (done) begin
        if (exp_res.size() == 0) check(0, "R9 unexpected done", {fail, timeout}, 0);
        else begin
          logic [1:0] e; string t;
          e = exp_res.pop_front(); t = res_tag.pop_front();
          check({fail, timeout} == e, t, {fail, timeout}, e);
        end
      end
    end
    we_prev = we_n;
  end

  function automatic logic [7:0] pcode(input logic [1:0] a);
    return (a == 2'd0) ? 8'h00 : (a == 2'd1) ? 8'h01 : 8'h50;
  endfunction

  task automatic run_op(input logic [1:0] op, input logic [1:0] area, input logic [7:0] col,
                        input logic [15:0] row, input int len, input logic sf, input int blen,
                        input logic [1:0] eres, input string rtag);
    logic [15:0] r;
    sts_fail = sf; busy_len = 16'(blen);
    pbase = col ^ 8'h5A; wstart = widx;
    r = (op == 2'd1) ? (row & 16'hFFF0) : row;
    if (op != 2'd1) push(pcode(area), 1, 0, "R3 pointer code");
    if (op == 2'd0) push(8'h80, 1, 0, "R3 80h right after pointer");
    if (op == 2'd1) push(8'h60, 1, 0, "R4 erase setup");
    if (op != 2'd1) push(col, 0, 1, "R2 column byte");
    push(r[7:0], 0, 1, (op == 2'd1) ? "R4 masked row low" : "R2 row low");
    push(r[15:8], 0, 1, (op == 2'd1) ? "R4 row high" : "R2 row high");
    if (op == 2'd0) for (int i = 0; i < len; i++) push(pbase + 8'(i), 0, 0, "R2 data byte");
    if (op == 2'd0) push(8'h10, 1, 0, "R2 program confirm");
    if (op == 2'd1) push(8'hD0, 1, 0, "R4 erase confirm");
    if (op != 2'd2) push(8'h70, 1, 0, "R5 status command");
    if (op == 2'd2) for (int i = 0; i < len; i++) exp_rd.push_back(col + 8'(i));
    exp_res.push_back(eres); res_tag.push_back(rtag);
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready before request", req_ready, 1);
    req_op = op; req_area = area; req_col = col; req_row = row; req_len = 10'(len);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    if (op == 2'd0) check(widx - wstart == len, "R10 wr_take count", widx - wstart, len);
    while (!rb) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(we_n && re_n && !cle && !ale && !dq_oe, "R1 idle bus", {we_n, re_n, cle, ale, dq_oe}, 5'b11000);
    check(req_ready && !done, "R1 ready, no done", {req_ready, done}, 2'b10);

    run_op(2'd0, 2'd0, 8'h05, 16'h1234, 4, 1'b0, 60, 2'b00, "R5 program pass");
    run_op(2'd0, 2'd1, 8'h80, 16'h0042, 3, 1'b1, 45, 2'b10, "R5 program fail bit");
    run_op(2'd0, 2'd2, 8'h03, 16'h0777, 2, 1'b0, 30, 2'b00, "R5 spare program pass");
    run_op(2'd1, 2'd0, 8'h00, 16'h1237, 0, 1'b0, 80, 2'b00, "R5 erase pass");
    run_op(2'd2, 2'd0, 8'h10, 16'h0100, 5, 1'b0, 40, 2'b00, "R6 read done");
    run_op(2'd2, 2'd1, 8'hF0, 16'h0200, 2, 1'b0, 25, 2'b00, "R6 second-half read done");
    run_op(2'd0, 2'd0, 8'h20, 16'h0300, 1, 1'b0, 2000, 2'b11, "R7 timeout");
    fork
      run_op(2'd1, 2'd0, 8'h00, 16'h00AF, 0, 1'b1, 150, 2'b10, "R9 erase fail with ignored request");
      begin
        repeat (30) @(negedge clk);
        req_op = 2'd2; req_valid = 1'b1;
        repeat (20) @(negedge clk);
        req_valid = 1'b0;
      end
    join
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R9 bus items left", exp_q.size(), 0);
    check(exp_rd.size() == 0, "R6 read bytes left", exp_rd.size(), 0);
    check(exp_res.size() == 0, "R9 results left", exp_res.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule